// File: doc/BRIEF.md
# Timer Expiry Order and Watchdog Checker

This block watches a bank of fifteen hardware timer slots, numbered 0 to 14, from the outside. It does not own the timers. It only sees an event each time one of them expires, tagged with that slot's number. The bench or chip that drives the timers arms them so that they run out in strict descending order, from slot 14 down to slot 0, and then start again at 14. The checker keeps its own pointer to the slot it expects next. It pulses an error when a different slot fires.

Each slot also has a small watchdog count. An expiry of a slot refills that slot's count. A periodic sweep strobe walks the bank one slot per cycle, from slot 14 down to slot 0, and lowers each count by one. A slot that goes too many sweeps without expiring runs its count down to zero. That raises a fail pulse, adds one to a saturating fail tally and refills the count. Completed sweeps are grouped into passes, and passes into a full run, which is marked by a one-cycle done pulse.

Top module: `timer_order_watchdog`

## Requirements
- R1: After reset, the expected slot is 14, every watchdog count holds 32, `fail_cnt` is 0, and `order_err`, `to_fail` and `pass_done` are low.
- R2: An expiry whose slot equals the expected slot raises no error and moves the expected slot down by one. After slot 0 it moves back to 14.
- R3: An expiry whose slot differs from the expected slot, including slot code 15, pulses `order_err` high for one cycle, starting the cycle after the event. The expected slot stays unchanged.
- R4: An expiry of slot s, where s is in 0..14, sets that slot's count back to 32. Slot code 15 refills no count.
- R5: A `sweep` strobe seen while no sweep is in progress starts a walk. In each of the next 15 cycles it lowers one slot's count by one, in the order 14, 13, …, 0. A strobe seen during a walk is ignored.
- R6: When a walk step takes a count from 1 to 0, `to_fail` pulses high for one cycle, starting the next cycle, and that count is set back to 32. A slot that never expires therefore fails on every 32nd sweep.
- R7: Each `to_fail` pulse adds one to `fail_cnt`. The tally holds at its maximum value, and only reset clears it.
- R8: When an expiry of a slot arrives in the same cycle as the walk step for that slot, the refill wins. No decrement and no failure follow from that step.
- R9: Every completed walk advances a sweep count. After 64 sweeps, that count restarts and a pass count advances. When the pass count completes 2560 passes, it clears and `pass_done` pulses high for one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_valid | input | 1 | An expiry event is present this cycle |
| ev_slot | input | 4 | Slot number of the expiry event (15 is out of range) |
| sweep | input | 1 | Request to start a decrement walk |
| order_err | output | 1 | One-cycle pulse for an out-of-order expiry |
| to_fail | output | 1 | One-cycle pulse when a watchdog count runs out |
| fail_cnt | output | 16 | Saturating tally of watchdog failures |
| pass_done | output | 1 | One-cycle pulse when the last pass of a run completes |

## Verification
The assertions assume `ev_slot` carries a value only when `ev_valid` is high. They also assume that, once reset is released, it stays released for long stretches, so the walk and the counters evolve without interruption. The bench meets the first assumption by driving a slot code on every cycle but judging it only together with the valid flag. It meets the second by applying reset only between phases at negedges. The stimulus mixes in-order expiries, wrong slots and slot code 15 with frequent sweep strobes, so expiries often collide with walk steps. One long phase sends no expiries at all, which drives every slot through repeated timeouts and saturates a narrowed tally.

// File: rtl/timer_order_watchdog.sv
`timescale 1ns/1ps
module timer_order_watchdog #(
  parameter int NSLOT           = 15,
  parameter int RELOAD          = 32,
  parameter int SWEEPS_PER_PASS = 64,
  parameter int PASSES          = 2560,
  parameter int FAIL_W          = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         ev_valid,
  input  logic [$clog2(NSLOT+1)-1:0]   ev_slot,
  input  logic                         sweep,
  output logic                         order_err,
  output logic                         to_fail,
  output logic [FAIL_W-1:0]            fail_cnt,
  output logic                         pass_done
);
  localparam int SW  = $clog2(NSLOT+1);
  localparam int CW  = $clog2(RELOAD+1);
  localparam int SCW = $clog2(SWEEPS_PER_PASS+1);
  localparam int PCW = $clog2(PASSES+1);
  localparam logic [SW-1:0]  TOP_SLOT = SW'(NSLOT-1);
  localparam logic [CW-1:0]  FULL     = CW'(RELOAD);
  localparam logic [SCW-1:0] SW_LAST  = SCW'(SWEEPS_PER_PASS-1);
  localparam logic [PCW-1:0] PS_LAST  = PCW'(PASSES-1);

  logic [CW-1:0]  cnt [NSLOT];
  logic [SW-1:0]  exp_slot, idx;
  logic           busy;
  logic [SCW-1:0] sw_cnt;
  logic [PCW-1:0] pass_cnt;
  logic [CW-1:0]  cur_cnt;

  wire in_range   = ev_valid && (ev_slot <= TOP_SLOT);
  wire match      = ev_valid && (ev_slot == exp_slot);
  wire collide    = busy && in_range && (ev_slot == idx);
  wire step_fail  = busy && !collide && (cur_cnt == CW'(1));
  wire walk_end   = busy && (idx == '0);
  wire sweep_wrap = walk_end && (sw_cnt == SW_LAST);
  wire pass_wrap  = sweep_wrap && (pass_cnt == PS_LAST);

  always_comb begin
    cur_cnt = FULL;
    for (int i = 0; i < NSLOT; i++)
      if (idx == SW'(i)) cur_cnt = cnt[i];
  end

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)                                 cnt[g] <= FULL;
      else if (in_range && ev_slot == SW'(g))     cnt[g] <= FULL;
      else if (busy && idx == SW'(g))             cnt[g] <= (cnt[g] == CW'(1)) ? FULL : cnt[g] - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      busy <= 1'b0;
      idx  <= '0;
    end else if (busy) begin
      busy <= !walk_end;
      if (!walk_end) idx <= idx - SW'(1);
    end else if (sweep) begin
      busy <= 1'b1;
      idx  <= TOP_SLOT;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)     exp_slot <= TOP_SLOT;
    else if (match) exp_slot <= (exp_slot == '0) ? TOP_SLOT : exp_slot - SW'(1);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sw_cnt   <= '0;
      pass_cnt <= '0;
    end else if (walk_end) begin
      sw_cnt <= sweep_wrap ? '0 : sw_cnt + SCW'(1);
      if (sweep_wrap) pass_cnt <= pass_wrap ? '0 : pass_cnt + PCW'(1);
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      order_err <= 1'b0;
      to_fail   <= 1'b0;
      pass_done <= 1'b0;
      fail_cnt  <= '0;
    end else begin
      order_err <= ev_valid && !match;
      to_fail   <= step_fail;
      pass_done <= pass_wrap;
      if (step_fail && fail_cnt != '1) fail_cnt <= fail_cnt + FAIL_W'(1);
    end

  AST_EXP_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n) exp_slot <= TOP_SLOT); // R2
  AST_ERR_HOLDS_EXP: assert property (@(posedge clk) disable iff (!rst_n) order_err |-> $stable(exp_slot)); // R3
  AST_FAIL_IN_WALK: assert property (@(posedge clk) disable iff (!rst_n) to_fail |-> $past(busy)); // R6
  AST_TALLY_MONO: assert property (@(posedge clk) disable iff (!rst_n) 1'b1 |=> fail_cnt >= $past(fail_cnt)); // R7
  AST_TALLY_STEP: assert property (@(posedge clk) disable iff (!rst_n) (!to_fail && $past(rst_n)) |-> $stable(fail_cnt)); // R7
  AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) pass_done |-> (pass_cnt == '0 && sw_cnt == '0)); // R9
  AST_IDLE_IGNORES: assert property (@(posedge clk) disable iff (!rst_n) (busy && idx != '0) |=> busy); // R5

  always_comb
    if (rst_n)
      for (int i = 0; i < NSLOT; i++)
        AST_CNT_LIVE: assert (cnt[i] != '0 && cnt[i] <= FULL); // R6
endmodule

// File: tb/tb_timer_order_watchdog.sv
`timescale 1ns/1ps
module tb_timer_order_watchdog;
  localparam int NS = 15, RL = 32, SPP = 4, NP = 3, FW = 5;

  logic clk = 0, rst_n = 0, ev_valid = 0, sweep = 0;
  logic [3:0] ev_slot = 0;
  logic order_err, to_fail, pass_done;
  logic [FW-1:0] fail_cnt;

  timer_order_watchdog #(.NSLOT(NS), .RELOAD(RL), .SWEEPS_PER_PASS(SPP), .PASSES(NP), .FAIL_W(FW)) dut (
    .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_slot(ev_slot), .sweep(sweep),
    .order_err(order_err), .to_fail(to_fail), .fail_cnt(fail_cnt), .pass_done(pass_done));

  always #2 clk = ~clk;

  int checks = 0, fails = 0;
  bit done_flag = 0;

  int m_cnt [NS];
  int m_exp, m_idx, m_sw, m_pass, m_fc;
  bit m_busy, e_oerr, e_fail, e_done, hit;
  int n_done = 0, n_fail = 0, n_oerr = 0;

  function automatic int next_exp(int e);
    return (e == 0) ? NS - 1 : e - 1;
  endfunction

  always @(posedge clk) begin
    e_oerr = 0; e_fail = 0; e_done = 0;
    if (!rst_n) begin
      for (int i = 0; i < NS; i++) m_cnt[i] = RL;
      m_exp = NS - 1; m_busy = 0; m_idx = 0; m_sw = 0; m_pass = 0; m_fc = 0;
    end else begin
      hit = ev_valid && ev_slot < NS;
      if (m_busy) begin
        if (!(hit && ev_slot == m_idx)) begin
          if (m_cnt[m_idx] == 1) begin
            e_fail = 1; m_cnt[m_idx] = RL;
            if (m_fc < (1 << FW) - 1) m_fc++;
          end else m_cnt[m_idx]--;
        end
        if (m_idx == 0) begin
          m_busy = 0;
          if (m_sw == SPP - 1) begin
            m_sw = 0;
            if (m_pass == NP - 1) begin m_pass = 0; e_done = 1; end
            else m_pass++;
          end else m_sw++;
        end else m_idx--;
      end else if (sweep) begin
        m_busy = 1; m_idx = NS - 1;
      end
      if (ev_valid) begin
        if (ev_slot == m_exp) m_exp = next_exp(m_exp);
        else e_oerr = 1;
        if (hit) m_cnt[ev_slot] = RL;
      end
    end
  end

  task automatic chk(string tag, int act, int expv);
    checks++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, expv, $time);
    end
  endtask

  task automatic cycle(bit v, int s, bit sw);
    @(negedge clk);
    chk("R2 R3 order_err", order_err, e_oerr);
    chk("R4 R5 R6 R8 to_fail", to_fail, e_fail);
    chk("R7 fail_cnt", fail_cnt, m_fc);
    chk("R9 pass_done", pass_done, e_done);
    if (to_fail) n_fail++;
    if (pass_done) n_done++;
    if (order_err) n_oerr++;
    ev_valid = v; ev_slot = 4'(s); sweep = sw;
  endtask

  task automatic rand_phase(int n, int ev_pct, int sw_pct);
    for (int k = 0; k < n; k++) begin
      int r, s;
      r = $urandom_range(99);
      if (r < 70) s = m_exp;
      else if (r < 90) s = $urandom_range(NS - 1);
      else s = 15;
      cycle($urandom_range(99) < ev_pct, s, $urandom_range(99) < sw_pct);
    end
  endtask

  initial begin
    void'($urandom(32'd1979));
    repeat (3) @(negedge clk);
    chk("R1 order_err", order_err, 0);
    chk("R1 to_fail", to_fail, 0);
    chk("R1 fail_cnt", fail_cnt, 0);
    chk("R1 pass_done", pass_done, 0);
    rst_n = 1;
    // R2: full descending cycle, then wrap back to 14
    for (int s = NS - 1; s >= 0; s--) cycle(1, s, 0);
    cycle(1, NS - 1, 0);
    cycle(0, 0, 0);
    chk("R2 no error over wrap", n_oerr, 0);
    // R3: slot code 15 and a wrong slot
    cycle(1, 15, 0);
    cycle(1, 3, 0);
    cycle(0, 0, 0);
    chk("R3 two error pulses", n_oerr, 2);
    // R5: strobe held high during a walk starts only one walk per idle period
    for (int k = 0; k < 40; k++) cycle(0, 0, 1);
    rand_phase(3000, 35, 12);
    // R6 R7 R9: no expiries, continuous sweeps, fails and tally saturation
    for (int k = 0; k < 1800; k++) cycle(0, 0, 1);
    chk("R7 tally saturated", fail_cnt, (1 << FW) - 1);
    chk("R6 timeouts seen", (n_fail > 0) ? 1 : 0, 1);
    chk("R9 run completions seen", (n_done > 0) ? 1 : 0, 1);
    // R7: reset clears the tally
    @(negedge clk); rst_n = 0; ev_valid = 0; sweep = 0;
    @(negedge clk);
    chk("R7 tally cleared by reset", fail_cnt, 0);
    chk("R1 order_err after reset", order_err, 0);
    rst_n = 1;
    // R8: dense expiries during walks produce many same-slot collisions
    rand_phase(2500, 60, 30);
    rand_phase(600, 5, 90);
    cycle(0, 0, 0);
    done_flag = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done_flag) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule